// File: doc/BRIEF.md
# Multiplexed Expansion Bus Write Sequencer

This block is the master side of a 16-bit multiplexed address/data expansion bus that talks to a DSP-style host port. A write request from the local side is taken through a valid/ready handshake. The block then runs one bus write through five programmable phases:

- **Address phase.** Chip select goes low and the address-latch strobe goes high. The address is on the shared lines.
- **Data setup phase.** The write data replaces the address on the shared lines.
- **Strobe phase.** The active-low data strobe is driven low.
- **Hold phase.** The strobe has risen again, and the data stays on the lines.
- **Recovery phase.** Chip select is released, and no new request is accepted.

Each phase length comes from a small configuration register set, and a phase programmed with value N lasts N+1 clocks. The target can assert an active-high wait line at any time. The line passes through a two-stage synchronizer. It can only stretch the address and strobe phases, and it always costs one extra clock after it clears.

Local back-pressure works as follows. `req_ready` is high only while the bus is idle, so at most one write is in flight. A request is taken on the first rising edge at which both `req_valid` and `req_ready` are high. The address and data are sampled only at that edge. Changes on `req_addr` and `req_data` at any other time have no effect on the bus. `wr_done` marks the last clock of the hold phase of each accepted write.

Top module: `mxbus_wr_seq`

## Requirements
- R1: While reset is applied and in the first cycle after it, `bus_cs_n`=1, `bus_strb_n`=1, `bus_ale`=0, `bus_ad_oe`=0, `wr_done`=0 and `req_ready`=1.
- R2: `req_ready` is 1 only while no write is in progress. In the first cycle after acceptance, `bus_cs_n`=0 and `bus_ale`=1 together, and `bus_ad_out` carries the accepted address.
- R3: A write runs through its phases in this order: address (`bus_ale`=1), setup (`bus_ale`=0, `bus_strb_n`=1), strobe (`bus_strb_n`=0), hold (`bus_strb_n`=1, `bus_cs_n`=0), recovery (`bus_cs_n`=1, `req_ready`=0). With no wait, each phase lasts its programmed value plus one clock, and `bus_ad_oe` is 1 exactly while `bus_cs_n` is 0.
- R4: A pulse on `cfg_we` loads `cfg_val` into the length selected by `cfg_sel`, using this encoding: 0 address, 1 setup, 2 strobe, 3 hold, 4 recovery. Codes 5 to 7 change nothing. A new value applies to every phase entered after the write.
- R5: Written values below the floors are raised to those floors. The floors are address 2, setup 2 and strobe 1, and hold and recovery have no floor. After reset the lengths are address 2, setup 2, strobe 1, hold 0 and recovery 0.
- R6: While the synchronized wait is high, the address and strobe phases do not end. Such a phase ends only at an edge where the synchronized wait was low in both the current and the previous cycle. As a result, after `bus_wait` falls, the held phase ends on the fourth rising edge, or later if its count has not yet run out.
- R7: `bus_wait` has no effect on the length of the setup, hold or recovery phases.
- R8: From the first setup clock to the last hold clock, `bus_ad_out` holds the accepted data without change.
- R9: `wr_done` is high for exactly one clock per write, in the last clock of the hold phase.
- R10: After the recovery phase, `req_ready` returns to 1 and the next request can be accepted.
- R11: Changes on `req_addr` and `req_data` after acceptance do not alter the address or data driven for the write in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Which phase length to write |
| cfg_val | input | CNT_W (6) | Phase length value N (phase lasts N+1 clocks) |
| req_valid | input | 1 | Local write request valid |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr | input | AD_W (16) | Write address |
| req_data | input | AD_W (16) | Write data |
| wr_done | output | 1 | One-clock pulse in the last hold clock |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_ale | output | 1 | Address-latch strobe, high during the address phase |
| bus_strb_n | output | 1 | Data strobe, active low |
| bus_ad_out | output | AD_W (16) | Multiplexed address/data lines, driven value |
| bus_ad_oe | output | 1 | Output enable for the shared lines |
| bus_wait | input | 1 | Target wait request, active high, asynchronous |

## Verification
A corrupted phase register or counter shows up at the pins within the write where it occurs. The effect is a phase whose clock count differs from the programmed value plus one, strobe edges out of order, a missing or doubled `wr_done`, or a `req_ready` that rises early. A fault in the wait path has a different signature. The address or strobe phase ends before the fourth edge after `bus_wait` falls, or the setup, hold or recovery length changes under a wait pulse, and both show within the same write. A data latch that reloads late shows as a change on `bus_ad_out` between setup and hold, or as the wrong address in the first `bus_ale` clock.

// File: rtl/mxbus_pkg.sv
`timescale 1ns/1ps
package mxbus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ADDR  = 3'd1,
    PH_SETUP = 3'd2,
    PH_STRB  = 3'd3,
    PH_HOLD  = 3'd4,
    PH_RECOV = 3'd5
  } phase_e;

  localparam int unsigned NUM_FIELDS = 5;
  localparam int unsigned F_ADDR  = 0;
  localparam int unsigned F_SETUP = 1;
  localparam int unsigned F_STRB  = 2;
  localparam int unsigned F_HOLD  = 3;
  localparam int unsigned F_RECOV = 4;

  // smallest legal value of each phase length field
  function automatic int unsigned field_floor(int unsigned f);
    case (f)
      F_ADDR:  return 2;
      F_SETUP: return 2;
      F_STRB:  return 1;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/mxbus_cfg.sv
`timescale 1ns/1ps
module mxbus_cfg
  import mxbus_pkg::*;
#(
  parameter int unsigned CNT_W = 6,
  parameter int unsigned SEL_W = 3
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  cfg_we,
  input  logic [SEL_W-1:0]                      cfg_sel,
  input  logic [CNT_W-1:0]                      cfg_val,
  output logic [NUM_FIELDS-1:0][CNT_W-1:0]      len_o
);

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    localparam logic [CNT_W-1:0] FLOOR = CNT_W'(field_floor(g));
    logic [CNT_W-1:0] len_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        len_q <= FLOOR;
      end else if (cfg_we && (cfg_sel == SEL_W'(g))) begin
        len_q <= (cfg_val < FLOOR) ? FLOOR : cfg_val;
      end
    end

    assign len_o[g] = len_q;
  end

endmodule

// File: rtl/mxbus_sync.sv
`timescale 1ns/1ps
module mxbus_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q[s] <= 1'b0;
      end else begin
        chain_q[s] <= (s == 0) ? d_i : chain_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/mxbus_fsm.sv
`timescale 1ns/1ps
module mxbus_fsm
  import mxbus_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             req_valid,
  input  logic [NUM_FIELDS-1:0][CNT_W-1:0] len_i,
  input  logic                             wait_sync,
  output logic                             wait_prev,
  output logic                             accept,
  output logic                             req_ready,
  output logic                             done,
  output phase_e                           phase
);

  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wait_prev_q;
  logic             cnt_zero;
  logic             stall;

  assign cnt_zero  = (cnt_q == '0);
  assign stall     = wait_sync || wait_prev_q;
  assign req_ready = (ph_q == PH_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_zero ? cnt_q : cnt_q - CNT_W'(1);
    case (ph_q)
      PH_IDLE: begin
        if (accept) begin
          ph_d  = PH_ADDR;
          cnt_d = len_i[F_ADDR];
        end
      end
      PH_ADDR: begin
        if (cnt_zero && !stall) begin
          ph_d  = PH_SETUP;
          cnt_d = len_i[F_SETUP];
        end
      end
      PH_SETUP: begin
        if (cnt_zero) begin
          ph_d  = PH_STRB;
          cnt_d = len_i[F_STRB];
        end
      end
      PH_STRB: begin
        if (cnt_zero && !stall) begin
          ph_d  = PH_HOLD;
          cnt_d = len_i[F_HOLD];
        end
      end
      PH_HOLD: begin
        if (cnt_zero) begin
          ph_d  = PH_RECOV;
          cnt_d = len_i[F_RECOV];
        end
      end
      PH_RECOV: begin
        if (cnt_zero) begin
          ph_d  = PH_IDLE;
        end
      end
      default: begin
        ph_d  = PH_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q        <= PH_IDLE;
      cnt_q       <= '0;
      wait_prev_q <= 1'b0;
    end else begin
      ph_q        <= ph_d;
      cnt_q       <= cnt_d;
      wait_prev_q <= wait_sync;
    end
  end

  assign done      = (ph_q == PH_HOLD) && cnt_zero;
  assign phase     = ph_q;
  assign wait_prev = wait_prev_q;

endmodule

// File: rtl/mxbus_drv.sv
`timescale 1ns/1ps
module mxbus_drv
  import mxbus_pkg::*;
#(
  parameter int unsigned AD_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  logic [AD_W-1:0] req_addr,
  input  logic [AD_W-1:0] req_data,
  input  phase_e          phase,
  output logic            cs_n,
  output logic            ale,
  output logic            strb_n,
  output logic [AD_W-1:0] ad_out,
  output logic            ad_oe
);

  logic [AD_W-1:0] addr_q, data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      addr_q <= req_addr;
      data_q <= req_data;
    end
  end

  always_comb begin
    cs_n   = 1'b1;
    ale    = 1'b0;
    strb_n = 1'b1;
    ad_out = '0;
    ad_oe  = 1'b0;
    case (phase)
      PH_ADDR: begin
        cs_n   = 1'b0;
        ale    = 1'b1;
        ad_out = addr_q;
        ad_oe  = 1'b1;
      end
      PH_SETUP, PH_HOLD: begin
        cs_n   = 1'b0;
        ad_out = data_q;
        ad_oe  = 1'b1;
      end
      PH_STRB: begin
        cs_n   = 1'b0;
        strb_n = 1'b0;
        ad_out = data_q;
        ad_oe  = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/mxbus_wr_seq.sv
`timescale 1ns/1ps
module mxbus_wr_seq
  import mxbus_pkg::*;
#(
  parameter int unsigned AD_W        = 16,
  parameter int unsigned CNT_W       = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_sel,
  input  logic [CNT_W-1:0] cfg_val,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AD_W-1:0]  req_addr,
  input  logic [AD_W-1:0]  req_data,
  output logic             wr_done,
  output logic             bus_cs_n,
  output logic             bus_ale,
  output logic             bus_strb_n,
  output logic [AD_W-1:0]  bus_ad_out,
  output logic             bus_ad_oe,
  input  logic             bus_wait
);

  logic [NUM_FIELDS-1:0][CNT_W-1:0] len;
  logic                             wait_sync;
  logic                             wait_prev;
  logic                             accept;
  phase_e                           phase;

  mxbus_cfg #(.CNT_W(CNT_W), .SEL_W(3)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_we  (cfg_we),
    .cfg_sel (cfg_sel),
    .cfg_val (cfg_val),
    .len_o   (len)
  );

  mxbus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (bus_wait),
    .q_o   (wait_sync)
  );

  mxbus_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .len_i     (len),
    .wait_sync (wait_sync),
    .wait_prev (wait_prev),
    .accept    (accept),
    .req_ready (req_ready),
    .done      (wr_done),
    .phase     (phase)
  );

  mxbus_drv #(.AD_W(AD_W)) u_drv (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .req_addr (req_addr),
    .req_data (req_data),
    .phase    (phase),
    .cs_n     (bus_cs_n),
    .ale      (bus_ale),
    .strb_n   (bus_strb_n),
    .ad_out   (bus_ad_out),
    .ad_oe    (bus_ad_oe)
  );

endmodule

// File: rtl/mxbus_wr_seq_chk.sv
`timescale 1ns/1ps
module mxbus_wr_seq_chk #(
  parameter int unsigned AD_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            wr_done,
  input logic            bus_cs_n,
  input logic            bus_ale,
  input logic            bus_strb_n,
  input logic [AD_W-1:0] bus_ad_out,
  input logic            bus_ad_oe,
  input logic            wait_sync,
  input logic            wait_prev
);

  p_addr_with_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_cs_n) |-> bus_ale);

  p_ready_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bus_cs_n && !bus_ale && bus_strb_n));

  p_oe_follows_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ad_oe == !bus_cs_n);

  p_addr_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_ale) |=> bus_ale ##1 bus_ale);

  p_strobe_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_strb_n) |=> !bus_strb_n);

  p_wait_holds_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ale && (wait_sync || wait_prev)) |=> bus_ale);

  p_wait_holds_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_strb_n && (wait_sync || wait_prev)) |=> !bus_strb_n);

  p_data_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_cs_n && !bus_ale && $past(!bus_cs_n && !bus_ale)) |-> $stable(bus_ad_out));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wr_done);

  p_done_in_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> (!bus_cs_n && bus_strb_n && !bus_ale));

  p_recovery_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_cs_n) |-> !req_ready);

endmodule

bind mxbus_wr_seq mxbus_wr_seq_chk #(.AD_W(AD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .wr_done    (wr_done),
  .bus_cs_n   (bus_cs_n),
  .bus_ale    (bus_ale),
  .bus_strb_n (bus_strb_n),
  .bus_ad_out (bus_ad_out),
  .bus_ad_oe  (bus_ad_oe),
  .wait_sync  (wait_sync),
  .wait_prev  (wait_prev)
);

// File: tb/tb_mxbus_wr_seq.sv
`timescale 1ns/1ps
module tb_mxbus_wr_seq;

  localparam int AD_W  = 16;
  localparam int CNT_W = 6;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cfg_we;
  logic [2:0]       cfg_sel;
  logic [CNT_W-1:0] cfg_val;
  logic             req_valid;
  logic             req_ready;
  logic [AD_W-1:0]  req_addr;
  logic [AD_W-1:0]  req_data;
  logic             wr_done;
  logic             bus_cs_n;
  logic             bus_ale;
  logic             bus_strb_n;
  logic [AD_W-1:0]  bus_ad_out;
  logic             bus_ad_oe;
  logic             bus_wait;

  always #2.5 clk = ~clk;

  mxbus_wr_seq #(.AD_W(AD_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_val(cfg_val),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_data(req_data),
    .wr_done(wr_done), .bus_cs_n(bus_cs_n), .bus_ale(bus_ale), .bus_strb_n(bus_strb_n),
    .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_wait(bus_wait)
  );

  int  checks = 0;
  int  errors = 0;
  bit  finished = 0;
  int  model_len[5];

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // floors from R5: address 2, setup 2, strobe 1, hold 0, recovery 0
  function automatic int floor_of(int sel);
    case (sel)
      0: return 2;
      1: return 2;
      2: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic int clamp_len(int sel, int v);
    return (v < floor_of(sel)) ? floor_of(sel) : v;
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic cfg_write(int sel, int v);
    @(negedge clk);
    cfg_we  = 1'b1;
    cfg_sel = 3'(sel);
    cfg_val = CNT_W'(v);
    @(negedge clk);
    cfg_we  = 1'b0;
    if (sel < 5) model_len[sel] = clamp_len(sel, v);  // R4: codes 5..7 ignored
  endtask

  // mode 0: no wait; 1: wait over address phase; 2: wait from setup through strobe;
  // 3: wait pulse across hold/recovery
  task automatic run_txn(int mode, int k, string tag);
    logic [AD_W-1:0] a, d;
    int A, S, P, H, Rc, dn, dn_at, bad_a, bad_d, guard;
    int eA, eS, eP, eH, eR;
    bit seen_p, released, raised;
    a = AD_W'($urandom); d = AD_W'($urandom);
    A = 0; S = 0; P = 0; H = 0; Rc = 0; dn = 0; dn_at = -1; bad_a = 0; bad_d = 0; guard = 0;
    seen_p = 0; released = 0; raised = 0;
    eA = model_len[0] + 1; eS = model_len[1] + 1; eP = model_len[2] + 1;
    eH = model_len[3] + 1; eR = model_len[4] + 1;
    if (mode == 1) eA = max2(eA, k + 3);
    if (mode == 2) eP = max2(eP, k + 3);
    if (mode == 1) begin
      bus_wait = 1'b1;
      repeat (3) @(negedge clk);
    end
    check(req_ready == 1'b1, "R10", {tag, " ready before request"}, int'(req_ready), 1);
    req_valid = 1'b1; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    req_addr = AD_W'($urandom); req_data = AD_W'($urandom);  // R11 scramble
    forever begin
      if (req_ready) break;
      if (bus_ale) begin
        A++;
        if (bus_cs_n || !bus_ad_oe || bus_ad_out !== a) bad_a++;
      end else if (!bus_cs_n && bus_strb_n && !seen_p) begin
        S++;
        if (!bus_ad_oe || bus_ad_out !== d) bad_d++;
      end else if (!bus_strb_n) begin
        P++; seen_p = 1;
        if (!bus_ad_oe || bus_ad_out !== d) bad_d++;
      end else if (!bus_cs_n) begin
        H++;
        if (!bus_ad_oe || bus_ad_out !== d) bad_d++;
      end else begin
        Rc++;
        if (bus_ad_oe) bad_d++;
      end
      if (wr_done) begin dn++; dn_at = H; end
      case (mode)
        1: if (!released && bus_ale && A == k) begin bus_wait = 1'b0; released = 1; end
        2: begin
          if (!raised && S == 1 && !seen_p) begin bus_wait = 1'b1; raised = 1; end
          if (raised && !released && seen_p && P == k) begin bus_wait = 1'b0; released = 1; end
        end
        3: begin
          if (!raised && H == 1) begin bus_wait = 1'b1; raised = 1; end
          if (raised && Rc == 1) bus_wait = 1'b0;
        end
        default: ;
      endcase
      @(negedge clk);
      req_addr = AD_W'($urandom); req_data = AD_W'($urandom);
      guard++;
      if (guard > 2000) begin
        check(1'b0, "R10", {tag, " write never returned to idle"}, guard, 0);
        break;
      end
    end
    bus_wait = 1'b0;
    check(A == eA, (mode == 1) ? "R6" : "R3", {tag, " address clocks"}, A, eA);
    check(S == eS, (mode == 2) ? "R7" : "R3", {tag, " setup clocks"}, S, eS);
    check(P == eP, (mode == 2) ? "R6" : "R3", {tag, " strobe clocks"}, P, eP);
    check(H == eH, (mode == 3) ? "R7" : "R3", {tag, " hold clocks"}, H, eH);
    check(Rc == eR, "R10", {tag, " recovery clocks"}, Rc, eR);
    check(dn == 1, "R9", {tag, " done pulses"}, dn, 1);
    check(dn_at == eH, "R9", {tag, " done position in hold"}, dn_at, eH);
    check(bad_a == 0, "R2", {tag, " address cycles wrong"}, bad_a, 0);
    check(bad_d == 0, "R8", {tag, " data cycles wrong (R11)"}, bad_d, 0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_len[0] = 2; model_len[1] = 2; model_len[2] = 1; model_len[3] = 0; model_len[4] = 0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_val = '0;
    req_valid = 1'b0; req_addr = '0; req_data = '0; bus_wait = 1'b0;
    repeat (3) @(negedge clk);
    // R1 in reset
    check(bus_cs_n == 1'b1 && bus_strb_n == 1'b1 && !bus_ale && !bus_ad_oe && !wr_done && req_ready,
          "R1", "outputs during reset", {bus_cs_n, bus_strb_n, bus_ale, bus_ad_oe, wr_done, req_ready}, 6'b110001);
    rst_n = 1'b1;
    @(negedge clk);
    check(bus_cs_n == 1'b1 && bus_strb_n == 1'b1 && !bus_ale && !bus_ad_oe && !wr_done && req_ready,
          "R1", "outputs after reset", {bus_cs_n, bus_strb_n, bus_ale, bus_ad_oe, wr_done, req_ready}, 6'b110001);

    // R5 reset lengths
    run_txn(0, 0, "R5 reset lengths");
    // R5 clamping
    cfg_write(0, 0); cfg_write(1, 1); cfg_write(2, 0); cfg_write(3, 0); cfg_write(4, 0);
    run_txn(0, 0, "R5 clamp");
    // R4 legal writes then ignored codes
    cfg_write(0, 5); cfg_write(1, 4); cfg_write(2, 3); cfg_write(3, 5); cfg_write(4, 7);
    cfg_write(5, 40); cfg_write(6, 40); cfg_write(7, 40);
    run_txn(0, 0, "R4 writes and ignored codes");
    // R6 wait on address phase: short and long release
    cfg_write(0, 2);
    run_txn(1, 1, "R6 addr k1");
    run_txn(1, 8, "R6 addr k8");
    cfg_write(0, 9);
    run_txn(1, 2, "R6 addr count dominates");
    // R6/R7 wait across setup and strobe
    cfg_write(1, 6); cfg_write(2, 1);
    run_txn(2, 5, "R6 strobe k5");
    // R7 wait during hold/recovery
    run_txn(3, 0, "R7 hold wait");

    for (int i = 0; i < 40; i++) begin
      int nw;
      nw = $urandom_range(0, 3);
      for (int j = 0; j < nw; j++) cfg_write($urandom_range(0, 7), $urandom_range(0, 12));
      run_txn($urandom_range(0, 3), $urandom_range(1, 8), "random");
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule